// File: doc/BRIEF.md
# Stereo PDM Decimation Filter

This block turns a stereo 1-bit pulse-density stream into a pair of signed 20-bit PCM samples. Both channels share one data line. The bit that is present at the rising edge of the PDM clock belongs to the left channel, and the bit that is present at the falling edge belongs to the right channel. Both bits are brought into a single rising-edge domain as one aligned pair. Each channel then passes through a fourth-order integrate/comb decimator that reduces the rate by 64. After that comes an optional three-tap droop compensator and a rounding, saturating reduction to 20 bits. Every stage is clocked by the PDM clock.

Each 64-clock frame produces one left/right pair, and both samples come from the same decimation instant. The pair leaves through a valid/ready stream. The source bits cannot be stalled, so back-pressure never holds up the filter. While a pair is waiting and has not been taken, the output holds its data and valid stays high. If the next frame completes before the pending pair is accepted, the new pair replaces it. For the first 48 frames after reset the samples are forced to zero, but valid still pulses, so downstream framing is the same as in normal running.

Top module: `pdm_decim_top`

## Requirements
- R1: While reset is asserted and right after it is released, out_valid is 0 and out_left and out_right are all zeros.
- R2: With out_ready held at 1, out_valid is a one-cycle pulse that repeats exactly every 64 clock cycles.
- R3: The left sample is built only from bits sampled at rising clock edges, and the right sample only from bits sampled at falling edges. A pattern on one channel has no effect on the other channel.
- R4: Once the filter has settled (8 frames after the input pattern changes), a channel fed a repeating 64-bit pattern that holds k ones produces the two's-complement value (2k−64)·8192. For example, k=32 gives 0 and k=48 gives 0x40000.
- R5: When the scaled result goes beyond the 20-bit range it saturates. A channel of all ones gives 0x7FFFF, and a channel of all zeros gives 0x80000.
- R6: The first 48 output pairs after reset are zero on both channels, and out_valid still pulses for each of them. The 49th pair carries filtered data.
- R7: While out_valid is 1 and out_ready is 0, out_valid stays 1 and the data stays unchanged until the next frame completes.
- R8: When a frame completes, out_valid is 1 in the following cycle with the new pair. This holds whether the previous pair was pending, and it holds when out_ready accepts the previous pair in that same cycle.
- R9: When out_ready is 1 while out_valid is 1 and no frame completes in that cycle, out_valid is 0 in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | PDM bit clock; every stage runs on it |
| rst_n | input | 1 | Asynchronous active-low reset |
| pdm_dat | input | 1 | Shared PDM data: left at the rising edge, right at the falling edge |
| out_valid | output | 1 | A PCM pair is being presented |
| out_ready | input | 1 | The consumer accepts the pair in this cycle |
| out_left | output | 20 | Left PCM sample, two's complement |
| out_right | output | 20 | Right PCM sample, two's complement |

## Verification
Two events can fall on the same clock edge: a new frame completing and the consumer accepting the pair that is still pending. The correct result is that the new pair is presented and out_valid stays high. To provoke this, the bench finds the frame phase from a valid pulse with ready high, then withholds ready for ten frames while it switches the input pattern. It raises ready exactly on the edge where the tenth following frame loads. In the next cycle it expects valid high carrying the new pattern's value, and one cycle after that it expects valid low.

// File: rtl/pdm_decim_pkg.sv
package pdm_decim_pkg;
  localparam int DEC_RATIO   = 64;
  localparam int CIC_ORDER   = 4;
  localparam int OUT_W       = 20;
  localparam int MUTE_FRAMES = 48;
  localparam int NUM_CH      = 2;
  localparam int COMP_SHIFT  = 4;

  localparam int LOG2R    = $clog2(DEC_RATIO);
  localparam int GAIN_SH  = CIC_ORDER * LOG2R;
  localparam int ACC_W    = GAIN_SH + 2;
  localparam int CMP_W    = ACC_W + 3;
  localparam int ROUND_SH = GAIN_SH - (OUT_W - 1);
  localparam int PH_W     = LOG2R;
  localparam int MUTE_W   = $clog2(MUTE_FRAMES + 1);

  localparam logic signed [CMP_W-1:0] SAT_HI = CMP_W'((1 << (OUT_W - 1)) - 1);
  localparam logic signed [CMP_W-1:0] SAT_LO = -SAT_HI - CMP_W'(1);

  function automatic logic [OUT_W-1:0] round_sat(input logic signed [CMP_W-1:0] y);
    logic signed [CMP_W-1:0] t;
    t = (y + CMP_W'(1 << (ROUND_SH - 1))) >>> ROUND_SH;
    if (t > SAT_HI)      return SAT_HI[OUT_W-1:0];
    else if (t < SAT_LO) return SAT_LO[OUT_W-1:0];
    else                 return t[OUT_W-1:0];
  endfunction
endpackage

// File: rtl/pdm_edge_split.sv
module pdm_edge_split
  import pdm_decim_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              pdm_dat,
  output logic [NUM_CH-1:0] bits_o
);
  logic rise_q, rise_d, fall_n, fall_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rise_q <= 1'b0;
      rise_d <= 1'b0;
    end else begin
      rise_q <= pdm_dat;
      rise_d <= rise_q;
    end
  end

  always_ff @(negedge clk or negedge rst_n) begin
    if (!rst_n) fall_n <= 1'b0;
    else        fall_n <= pdm_dat;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) fall_q <= 1'b0;
    else        fall_q <= fall_n;
  end

  // left bit from edge k and right bit from the half-cycle after it, aligned
  assign bits_o = {fall_q, rise_d};

  // R3: the right bit re-registered into the rising domain is the falling-edge sample
  a_r3_fall_transfer: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (fall_q == $past(fall_n)));
endmodule

// File: rtl/pdm_cic_chan.sv
module pdm_cic_chan
  import pdm_decim_pkg::*;
#(
  parameter bit COMP_EN = 1'b1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bit_i,
  input  logic             dec_stb,
  output logic             y_stb,
  output logic [OUT_W-1:0] y_o
);
  logic signed [ACC_W-1:0] integ [CIC_ORDER];
  logic signed [ACC_W-1:0] cdly  [CIC_ORDER];
  logic signed [ACC_W-1:0] cin   [CIC_ORDER+1];
  logic signed [ACC_W-1:0] x_in;

  assign x_in = bit_i ? ACC_W'(1) : {ACC_W{1'b1}};

  for (genvar s = 0; s < CIC_ORDER; s++) begin : g_int
    logic signed [ACC_W-1:0] src;
    if (s == 0) begin : g_first
      assign src = x_in;
    end else begin : g_next
      assign src = integ[s-1];
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) integ[s] <= '0;
      else        integ[s] <= integ[s] + src;
    end
  end

  assign cin[0] = integ[CIC_ORDER-1];
  for (genvar s = 0; s < CIC_ORDER; s++) begin : g_comb
    assign cin[s+1] = cin[s] - cdly[s];
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       cdly[s] <= '0;
      else if (dec_stb) cdly[s] <= cin[s];
    end
  end

  logic signed [CMP_W-1:0] e0, y_c;
  assign e0 = {{(CMP_W-ACC_W){cin[CIC_ORDER][ACC_W-1]}}, cin[CIC_ORDER]};

  if (COMP_EN) begin : g_comp
    logic signed [CMP_W-1:0] e1, e2, diff;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        e1 <= '0;
        e2 <= '0;
      end else if (dec_stb) begin
        e1 <= e0;
        e2 <= e1;
      end
    end
    assign diff = (e1 <<< 1) - e0 - e2;
    assign y_c  = e1 + (diff >>> COMP_SHIFT);
  end else begin : g_nocomp
    assign y_c = e0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      y_stb <= 1'b0;
      y_o   <= '0;
    end else begin
      y_stb <= dec_stb;
      if (dec_stb) y_o <= round_sat(y_c);
    end
  end

  // R2: a result appears exactly one cycle after each decimation instant
  a_r2_result_follows: assert property (@(posedge clk) disable iff (!rst_n)
    y_stb |-> $past(dec_stb));
endmodule

// File: rtl/pdm_decim_top.sv
module pdm_decim_top
  import pdm_decim_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             pdm_dat,
  output logic             out_valid,
  input  logic             out_ready,
  output logic [OUT_W-1:0] out_left,
  output logic [OUT_W-1:0] out_right
);
  logic [NUM_CH-1:0] bits;
  logic [PH_W-1:0]   phase;
  logic              dec_stb;
  logic [NUM_CH-1:0] y_stb;
  logic [OUT_W-1:0]  y_val [NUM_CH];
  logic [MUTE_W-1:0] mute_cnt;
  logic              muted, load;

  pdm_edge_split u_split (
    .clk    (clk),
    .rst_n  (rst_n),
    .pdm_dat(pdm_dat),
    .bits_o (bits)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) phase <= '0;
    else        phase <= phase + PH_W'(1);
  end
  assign dec_stb = (phase == PH_W'(DEC_RATIO - 1));

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    pdm_cic_chan #(.COMP_EN(1'b1)) u_cic (
      .clk    (clk),
      .rst_n  (rst_n),
      .bit_i  (bits[c]),
      .dec_stb(dec_stb),
      .y_stb  (y_stb[c]),
      .y_o    (y_val[c])
    );
  end

  assign load  = y_stb[0];
  assign muted = (mute_cnt < MUTE_W'(MUTE_FRAMES));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)             mute_cnt <= '0;
    else if (load && muted) mute_cnt <= mute_cnt + MUTE_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_left  <= '0;
      out_right <= '0;
    end else if (load) begin
      out_valid <= 1'b1;
      out_left  <= muted ? '0 : y_val[0];
      out_right <= muted ? '0 : y_val[1];
    end else if (out_ready) begin
      out_valid <= 1'b0;
    end
  end

  // R2: decimation instants are never adjacent
  a_r2_stb_spacing: assert property (@(posedge clk) disable iff (!rst_n)
    dec_stb |=> !dec_stb);
  // R6: a pair loaded during the start-up window is zero
  a_r6_mute_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (load && muted) |=> (out_valid && out_left == '0 && out_right == '0));
  // R7: a pending pair is held while the consumer stalls
  a_r7_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready && !load) |=>
      (out_valid && $stable(out_left) && $stable(out_right)));
  // R8: a completed frame is always presented, even on a same-cycle accept
  a_r8_load_wins: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> out_valid);
  // R9: an accepted pair is withdrawn when no frame completes
  a_r9_release: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_ready && !load) |=> !out_valid);
endmodule

// File: tb/pdm_decim_top_tb_top.sv
module pdm_decim_top_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        pdm_dat = 1'b0;
  logic        out_ready = 1'b1;
  logic        out_valid;
  logic [19:0] out_left, out_right;

  logic [63:0] pat_l = '1, pat_r = '1;
  int checks = 0, failures = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  pdm_decim_top dut_i (
    .clk(clk), .rst_n(rst_n), .pdm_dat(pdm_dat),
    .out_valid(out_valid), .out_ready(out_ready),
    .out_left(out_left), .out_right(out_right)
  );

  // left bit stable around rising edge, right bit around falling edge
  initial begin
    int idx = 0;
    forever begin
      @(posedge clk);
      #5 pdm_dat = pat_r[idx];
      #10;
      idx = (idx + 1) % 64;
      pdm_dat = pat_l[idx];
    end
  end

  function automatic logic [19:0] exp_val(input logic [63:0] p);
    int v;
    v = (2 * $countones(p) - 64) * 8192;
    if (v > 524287) v = 524287;
    return 20'(v);
  endfunction

  task automatic check(input bit ok, input string tag, input logic [39:0] act, input logic [39:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wait_pulse();
    int n = 0;
    do begin
      @(negedge clk);
      n++;
    end while (!out_valid && n < 200);
  endtask

  task automatic skip_frames(input int n);
    for (int i = 0; i < n; i++) wait_pulse();
  endtask

  task automatic check_pair(input string tag);
    check(out_left == exp_val(pat_l) && out_right == exp_val(pat_r), tag,
          {out_left, out_right}, {exp_val(pat_l), exp_val(pat_r)});
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    failures++;
    checks++;
    $display("FAIL watchdog expired actual=running expected=finished");
    finish_run();
  end

  initial begin
    int t0, t1;
    int zero_ok;
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    // R1: reset state
    check(out_valid == 1'b0 && out_left == '0 && out_right == '0, "R1 in reset",
          {out_valid, out_left, out_right}, 40'h0);
    rst_n = 1'b1;
    @(negedge clk);
    check(out_valid == 1'b0 && out_left == '0 && out_right == '0, "R1 after release",
          {out_valid, out_left, out_right}, 40'h0);

    // R6: 48 muted pairs with all-ones input, then data
    zero_ok = 1;
    for (int i = 0; i < 48; i++) begin
      wait_pulse();
      if (out_left != '0 || out_right != '0) zero_ok = 0;
    end
    check(zero_ok == 1, "R6 muted pairs zero", 40'(zero_ok), 40'd1);
    wait_pulse();
    // R5: full-density input saturates positive
    check(out_left == 20'h7FFFF && out_right == 20'h7FFFF, "R6 R5 49th pair positive full scale",
          {out_left, out_right}, {20'h7FFFF, 20'h7FFFF});

    // R2: pulse width one cycle, period 64
    t0 = 0;
    @(negedge clk);
    check(out_valid == 1'b0, "R2 pulse width", 40'(out_valid), 40'd0);
    t1 = 1;
    while (!out_valid && t1 < 200) begin
      @(negedge clk);
      t1++;
    end
    check(t1 - t0 == 64, "R2 period", 40'(t1 - t0), 40'd64);

    // R5: all zeros saturates negative
    pat_l = '0; pat_r = '0;
    skip_frames(8); wait_pulse();
    check_pair("R5 all zeros negative full scale");

    // R4: directed densities
    pat_l = {32{2'b01}}; pat_r = {16{4'b0111}};
    skip_frames(8); wait_pulse();
    check_pair("R4 k=32 left, k=48 right");

    // R3: one channel full, other empty, then swapped
    pat_l = '1; pat_r = '0;
    skip_frames(8); wait_pulse();
    check_pair("R3 left ones right zeros");
    pat_l = '0; pat_r = '1;
    skip_frames(8); wait_pulse();
    check_pair("R3 left zeros right ones");

    // R4: random patterns, independent per channel
    for (int i = 0; i < 12; i++) begin
      pat_l = {$urandom, $urandom};
      pat_r = {$urandom, $urandom};
      if (i == 3) pat_l = 64'h1;
      if (i == 4) pat_r = 64'hFFFF_FFFF_FFFF_FFFE;
      skip_frames(8); wait_pulse();
      check_pair($sformatf("R4 R3 random %0d", i));
    end

    // R7/R8/R9: back-pressure and the same-cycle load/accept
    pat_l = {16{4'b0011}}; pat_r = {16{4'b0001}};
    skip_frames(8);
    wait_pulse();                 // pulse observed: load edge n
    out_ready = 1'b0;
    begin
      logic [19:0] hold_l, hold_r;
      hold_l = out_left; hold_r = out_right;
      pat_l = {16{4'b0111}}; pat_r = {32{2'b01}};
      repeat (30) @(negedge clk);   // n+30
      check(out_valid == 1'b1 && out_left == hold_l && out_right == hold_r, "R7 held while stalled",
            {out_valid, out_left, out_right}, {1'b1, hold_l, hold_r});
      repeat (570) @(negedge clk);  // n+600
      check(out_valid == 1'b1, "R7 valid kept across frames", 40'(out_valid), 40'd1);
      check_pair("R8 pending pair overwritten by newer frame");
      repeat (39) @(negedge clk);   // n+639
      out_ready = 1'b1;             // high on the load edge n+640
      @(negedge clk);               // n+640
      check(out_valid == 1'b1, "R8 load beats same-cycle accept", 40'(out_valid), 40'd1);
      check_pair("R8 new pair after same-cycle accept");
      @(negedge clk);               // n+641
      check(out_valid == 1'b0, "R9 released after accept", 40'(out_valid), 40'd0);
    end

    finish_run();
  end
endmodule